// File: doc/BRIEF.md
# Serial Receiver with Address-Wake Filter

This block receives asynchronous serial frames and holds the last accepted byte in a data register. Status flags report a full data register, a bad stop bit and a lost frame. The serial line is sampled 16 times per bit, using a baud tick supplied from outside. When the extended frame format is selected, each frame carries one extra flag bit after the data byte. That bit tells an address frame (1) apart from a data frame (0).

Software can arm a wake filter. While the filter is armed, data frames pass by without touching the data register or any status bit. The first address frame is taken in normally, and in the same clock hardware drops the arm bit, so every later frame is received as usual. This lets a node sleep through traffic meant for others on a shared line and wake up on each address. Two interrupt lines, one for received data and one for receive errors, are gated by a single enable bit.

Top module: `mp_uart_rx`

## Requirements
- R1: After a synchronous reset, the control word, the status word, the data register and both interrupt outputs are 0.
- R2: While control bit 0 (receiver on) is set, a frame is received as follows: a low start bit; 8 data bits, least significant first; one flag bit, present only when control bit 1 (extended format) is set; and a stop bit. Each bit is sampled after 16 baud ticks, the start bit after 8. An accepted frame with status bit 0 (full) clear loads the byte into rx_data and sets status bit 0. With control bit 0 clear, the line is ignored.
- R3: A start bit that is high again when sampled 8 ticks after the falling edge is discarded, with no effect on status or data.
- R4: An accepted frame whose stop bit is sampled low sets status bit 1 (framing error). Its byte is still transferred under the rules of R2 and R5.
- R5: An accepted frame that completes while status bit 0 is set sets status bit 2 (overrun). rx_data keeps its old value and status bit 0 stays set.
- R6: A status write clears each of bits 0 to 2 that is written as 0 and leaves each bit written as 1 unchanged. A flag set by hardware in the same clock stays set. Status bit 3 ignores writes.
- R7: Each accepted frame in extended format copies its flag bit into status bit 3. Frames in the plain format leave status bit 3 unchanged.
- R8: While the filter is active, a frame whose flag bit is 0 changes neither rx_data nor any status bit. The filter is active when control bit 4 (wake arm) is 1, control bit 1 is 1 and control bit 2 (clocked mode) is 0.
- R9: While the filter is active, a frame whose flag bit is 1 is accepted under R2, R4, R5 and R7. In the same clock in which the status updates, control bit 4 returns to 0.
- R10: With control bit 1 at 0 or control bit 2 at 1, control bit 4 has no effect: every frame is accepted, and control bit 4 keeps its value.
- R11: Control bit 4 is written and read back through the control word like the other control bits.
- R12: irq_rx_full equals control bit 3 (interrupt enable) AND status bit 0. irq_rx_err equals control bit 3 AND (status bit 1 OR status bit 2). Both follow the registers with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idles high |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 5 | Control word: on, extended format, clocked mode, interrupt enable, wake arm (bits 0 to 4) |
| sts_we | input | 1 | Write strobe for the status word (write 0 to clear) |
| sts_wdata | input | 4 | Status write data |
| ctl_rdata | output | 5 | Current control word |
| sts_rdata | output | 4 | Status: full, framing error, overrun, flag bit (bits 0 to 3) |
| rx_data | output | 8 | Data register |
| irq_rx_full | output | 1 | Receive-full interrupt |
| irq_rx_err | output | 1 | Receive-error interrupt |

## Verification
Frames are sent in the plain and the extended format, with flag bits of 0 and 1, with good and bad stop bits, and with the full flag set and clear. These cases separate a transfer, a framing error and an overrun. With the filter armed, a data frame sent into a full register shows that even the overrun check is skipped. The same arm bit is then tried with the plain format and with clocked mode selected, which shows that the filter acts only under both gating conditions. A short low pulse checks start-bit rejection, and status writes with mixed ones and zeros check per-bit clearing and the read-only flag bit.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;
  localparam int CTL_W   = 5;
  localparam int CB_ON   = 0;
  localparam int CB_MPF  = 1;
  localparam int CB_SYNC = 2;
  localparam int CB_RIE  = 3;
  localparam int CB_ARM  = 4;

  localparam int STS_W   = 4;
  localparam int SB_FULL = 0;
  localparam int SB_FE   = 1;
  localparam int SB_OVR  = 2;
  localparam int SB_MPB  = 3;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/mp_rx_sampler.sv
module mp_rx_sampler
  import mp_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mp_fmt,
  input  logic              baud_tick,
  input  logic              rx_in,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_mpb,
  output logic              done_stop
);
  localparam int CNT_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int SH_W  = DATA_W + 1;

  logic [SYNC_STAGES-1:0] sync;
  logic                   rx_s;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) sync <= '1;
        else     sync <= {sync[SYNC_STAGES-2:0], rx_in};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk) begin
        if (rst) sync <= '1;
        else     sync <= rx_in;
      end
    end
  endgenerate

  assign rx_s = sync[SYNC_STAGES-1];

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [SH_W-1:0]  sh;

  assign last_idx = mp_fmt ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      done  <= 1'b0;
      if (rst) begin
        sh        <= '0;
        done_data <= '0;
        done_mpb  <= 1'b0;
        done_stop <= 1'b0;
      end
    end else begin
      done <= 1'b0;
      if (baud_tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == CNT_W'(HALF - 1)) begin
              cnt <= '0;
              idx <= '0;
              state <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BITS: begin
            if (cnt == CNT_W'(OVS - 1)) begin
              cnt     <= '0;
              sh[idx] <= rx_s;
              if (idx == last_idx) state <= RX_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == CNT_W'(OVS - 1)) begin
              cnt       <= '0;
              done      <= 1'b1;
              done_data <= sh[DATA_W-1:0];
              done_mpb  <= mp_fmt & sh[DATA_W];
              done_stop <= rx_s;
              state     <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mp_rx_regs.sv
module mp_rx_regs
  import mp_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_mpb,
  input  logic              done_stop,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              sts_we,
  input  logic [STS_W-1:0]  sts_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [STS_W-1:0]  sts_q,
  output logic [DATA_W-1:0] data_q,
  output logic              irq_full,
  output logic              irq_err
);
  logic             filt_act;
  logic             accept;
  logic             wake;
  logic             load;
  logic [CTL_W-1:0] ctl_n;
  logic [STS_W-1:0] sts_n;

  assign filt_act = ctl_q[CB_ARM] & ctl_q[CB_MPF] & ~ctl_q[CB_SYNC];
  assign accept   = done & ~(filt_act & ~done_mpb);
  assign wake     = done & filt_act & done_mpb;
  assign load     = accept & ~sts_q[SB_FULL];

  always_comb begin
    ctl_n = ctl_we ? ctl_wdata : ctl_q;
    if (wake) ctl_n[CB_ARM] = 1'b0;
  end

  always_comb begin
    sts_n = sts_q;
    if (sts_we) begin
      sts_n[SB_FULL] = sts_q[SB_FULL] & sts_wdata[SB_FULL];
      sts_n[SB_FE]   = sts_q[SB_FE]   & sts_wdata[SB_FE];
      sts_n[SB_OVR]  = sts_q[SB_OVR]  & sts_wdata[SB_OVR];
    end
    if (accept) begin
      if (sts_q[SB_FULL]) sts_n[SB_OVR]  = 1'b1;
      else                sts_n[SB_FULL] = 1'b1;
      if (!done_stop)     sts_n[SB_FE]   = 1'b1;
      if (ctl_q[CB_MPF])  sts_n[SB_MPB]  = done_mpb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      sts_q    <= '0;
      data_q   <= '0;
      irq_full <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      ctl_q    <= ctl_n;
      sts_q    <= sts_n;
      if (load) data_q <= done_data;
      irq_full <= ctl_q[CB_RIE] & sts_q[SB_FULL];
      irq_err  <= ctl_q[CB_RIE] & (sts_q[SB_FE] | sts_q[SB_OVR]);
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rx_in,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              sts_we,
  input  logic [STS_W-1:0]  sts_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic [STS_W-1:0]  sts_rdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq_rx_full,
  output logic              irq_rx_err
);
  logic              smp_done;
  logic [DATA_W-1:0] smp_data;
  logic              smp_mpb;
  logic              smp_stop;
  logic [CTL_W-1:0]  ctl_q;
  logic [STS_W-1:0]  sts_q;

  mp_rx_sampler #(
    .DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk(clk), .rst(rst),
    .enable(ctl_q[CB_ON]), .mp_fmt(ctl_q[CB_MPF]),
    .baud_tick(baud_tick), .rx_in(rx_in),
    .done(smp_done), .done_data(smp_data),
    .done_mpb(smp_mpb), .done_stop(smp_stop)
  );

  mp_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .done(smp_done), .done_data(smp_data),
    .done_mpb(smp_mpb), .done_stop(smp_stop),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .ctl_q(ctl_q), .sts_q(sts_q), .data_q(rx_data),
    .irq_full(irq_rx_full), .irq_err(irq_rx_err)
  );

  assign ctl_rdata = ctl_q;
  assign sts_rdata = sts_q;
endmodule

// File: rtl/mp_rx_chk.sv
module mp_rx_chk
  import mp_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic [DATA_W-1:0] done_data,
  input logic              done_mpb,
  input logic              done_stop,
  input logic              ctl_we,
  input logic              sts_we,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [STS_W-1:0]  sts_q,
  input logic [DATA_W-1:0] data_q
);
  logic filt;
  logic acc;
  logic rst_d;

  assign filt = ctl_q[CB_ARM] && ctl_q[CB_MPF] && !ctl_q[CB_SYNC];
  assign acc  = done && !(filt && !done_mpb);

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d && !rst) begin
      p_reset_r1: assert (sts_q == '0 && data_q == '0 && ctl_q == '0)
        else $error("R1 reset state");
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && !sts_q[SB_FULL]) |=> (sts_q[SB_FULL] && data_q == $past(done_data)));

  p_frame_err_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && !done_stop) |=> sts_q[SB_FE]);

  p_overrun_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && sts_q[SB_FULL]) |=> (sts_q[SB_OVR] && $stable(data_q)));

  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (done && filt && !done_mpb && !sts_we) |=> ($stable(sts_q) && $stable(data_q)));

  p_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (done && filt && done_mpb && !ctl_we) |=> (!ctl_q[CB_ARM] && sts_q[SB_MPB]));
endmodule

bind mp_uart_rx mp_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .done(smp_done), .done_data(smp_data),
  .done_mpb(smp_mpb), .done_stop(smp_stop),
  .ctl_we(ctl_we), .sts_we(sts_we),
  .ctl_q(ctl_q), .sts_q(sts_q), .data_q(rx_data)
);

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
  localparam int OVS      = 16;
  localparam int SYNC     = 2;
  localparam int TICK_DIV = 2;
  localparam int BITCLK   = OVS * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       sts_we = 1'b0;
  logic [3:0] sts_wdata = '0;
  logic [4:0] ctl_rdata;
  logic [3:0] sts_rdata;
  logic [7:0] rx_data;
  logic       irq_rx_full, irq_rx_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mp_uart_rx i_mp_uart_rx (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_in(rx_in),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata), .rx_data(rx_data),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
  );

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    baud_tick <= (tdiv == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: per-clock, tick-counted frame reader
  logic [4:0] m_ctl;
  logic [3:0] m_sts;
  logic [7:0] m_data;
  logic       m_irqf, m_irqe;
  bit         m_done, m_dmpb, m_dstop;
  logic [7:0] m_dd;
  logic [8:0] m_bits;
  logic [SYNC-1:0] m_q;
  int m_mode, m_t, m_bitn;

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = '0; m_sts = '0; m_data = '0; m_irqf = 0; m_irqe = 0;
      m_done = 0; m_dmpb = 0; m_dstop = 0; m_dd = '0; m_bits = '0;
      m_mode = 0; m_t = 0; m_bitn = 0; m_q = '1;
    end else begin
      bit on_old, mpf_old, filt, acc, wake, rxv;
      logic [3:0] nsts;
      on_old  = m_ctl[0];
      mpf_old = m_ctl[1];
      m_irqf = m_ctl[3] & m_sts[0];
      m_irqe = m_ctl[3] & (m_sts[1] | m_sts[2]);
      filt = m_ctl[4] && m_ctl[1] && !m_ctl[2];
      acc  = m_done && !(filt && !m_dmpb);
      wake = m_done && filt && m_dmpb;
      nsts = m_sts;
      if (sts_we) nsts[2:0] = m_sts[2:0] & sts_wdata[2:0];
      if (acc) begin
        if (m_sts[0]) nsts[2] = 1'b1;
        else begin nsts[0] = 1'b1; m_data = m_dd; end
        if (!m_dstop) nsts[1] = 1'b1;
        if (m_ctl[1]) nsts[3] = m_dmpb;
      end
      m_sts = nsts;
      if (ctl_we) m_ctl = ctl_wdata;
      if (wake) m_ctl[4] = 1'b0;
      m_done = 0;
      rxv = m_q[SYNC-1];
      if (!on_old) begin
        m_mode = 0; m_t = 0; m_bitn = 0;
      end else if (baud_tick) begin
        if (m_mode == 0) begin
          if (!rxv) begin m_mode = 1; m_t = 0; end
        end else if (m_mode == 1) begin
          m_t++;
          if (m_t == OVS / 2) begin
            m_t = 0; m_bitn = 0;
            m_mode = rxv ? 0 : 2;
          end
        end else if (m_mode == 2) begin
          m_t++;
          if (m_t == OVS) begin
            m_t = 0;
            m_bits[m_bitn] = rxv;
            m_bitn++;
            if (m_bitn == (mpf_old ? 9 : 8)) m_mode = 3;
          end
        end else begin
          m_t++;
          if (m_t == OVS) begin
            m_t = 0; m_mode = 0;
            m_done = 1; m_dd = m_bits[7:0];
            m_dmpb = mpf_old & m_bits[8];
            m_dstop = rxv;
          end
        end
      end
    end
    m_q = {m_q[SYNC-2:0], rx_in};
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 data model", rx_data, m_data);
      chk("R6 status model", sts_rdata, m_sts);
      chk("R11 control model", ctl_rdata, m_ctl);
      chk("R12 irq model", {irq_rx_full, irq_rx_err}, {m_irqf, m_irqe});
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(input logic [4:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
    wait_clk(2);
  endtask

  task automatic wr_sts(input logic [3:0] v);
    @(negedge clk); sts_we = 1'b1; sts_wdata = v;
    @(negedge clk); sts_we = 1'b0;
    wait_clk(2);
  endtask

  task automatic send(input logic [7:0] d, input bit with_mp, input bit mpb, input bit stop);
    @(negedge clk);
    rx_in = 1'b0; wait_clk(BITCLK);
    for (int i = 0; i < 8; i++) begin rx_in = d[i]; wait_clk(BITCLK); end
    if (with_mp) begin rx_in = mpb; wait_clk(BITCLK); end
    rx_in = stop;
    if (stop) wait_clk(BITCLK);
    else      wait_clk(11 * TICK_DIV);
    rx_in = 1'b1; wait_clk(3 * BITCLK);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    chk("R1 status", sts_rdata, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 control", ctl_rdata, 0);
    chk("R1 irq", {irq_rx_full, irq_rx_err}, 0);

    // R11 arm bit read/write
    set_ctl(5'b10000);
    chk("R11 arm readback", ctl_rdata, 5'b10000);
    // receiver off: line ignored (R2)
    send(8'h5A, 0, 0, 1);
    chk("R2 off ignores line", sts_rdata, 0);

    // plain frame, interrupts enabled
    set_ctl(5'b01001);
    send(8'hA5, 0, 0, 1);
    chk("R2 byte", rx_data, 8'hA5);
    chk("R2 full", sts_rdata, 4'b0001);
    chk("R12 irq full", {irq_rx_full, irq_rx_err}, 2'b10);
    wr_sts(4'b1110);
    chk("R6 clear full", sts_rdata, 0);
    chk("R12 irq drop", {irq_rx_full, irq_rx_err}, 2'b00);

    // glitch start R3
    @(negedge clk); rx_in = 1'b0; wait_clk(3 * TICK_DIV); rx_in = 1'b1;
    wait_clk(3 * BITCLK);
    chk("R3 glitch status", sts_rdata, 0);
    chk("R3 glitch data", rx_data, 8'hA5);

    // framing error R4
    send(8'h3C, 0, 0, 0);
    chk("R4 byte", rx_data, 8'h3C);
    chk("R4 status", sts_rdata, 4'b0011);
    chk("R12 irq err", {irq_rx_full, irq_rx_err}, 2'b11);

    // overrun R5
    send(8'h77, 0, 0, 1);
    chk("R5 data kept", rx_data, 8'h3C);
    chk("R5 status", sts_rdata, 4'b0111);
    wr_sts(4'b1101);
    chk("R6 partial clear", sts_rdata, 4'b0101);
    wr_sts(4'b0000);
    chk("R6 clear all", sts_rdata, 0);

    // extended format, filter off R7
    set_ctl(5'b00011);
    send(8'h12, 1, 0, 1);
    chk("R7 data frame", sts_rdata, 4'b0001);
    chk("R7 byte", rx_data, 8'h12);
    wr_sts(4'b1110);
    send(8'h34, 1, 1, 1);
    chk("R7 address frame", sts_rdata, 4'b1001);
    wr_sts(4'b0000);
    chk("R6 flag bit read-only", sts_rdata, 4'b1000);

    // armed filter R8 / R9
    set_ctl(5'b10011);
    send(8'h55, 1, 0, 0);
    chk("R8 drop status", sts_rdata, 4'b1000);
    chk("R8 drop data", rx_data, 8'h34);
    chk("R8 arm kept", ctl_rdata, 5'b10011);
    send(8'h81, 1, 1, 1);
    chk("R9 byte", rx_data, 8'h81);
    chk("R9 status", sts_rdata, 4'b1001);
    chk("R9 arm cleared", ctl_rdata, 5'b00011);
    send(8'h90, 1, 0, 1);
    chk("R9 resumed normal", sts_rdata, 4'b0101);
    wr_sts(4'b1011);
    chk("R6 clear overrun", sts_rdata, 4'b0001);

    // armed with full set: no overrun from dropped frame
    set_ctl(5'b10011);
    send(8'hEE, 1, 0, 1);
    chk("R8 no overrun", sts_rdata, 4'b0001);
    send(8'hC3, 1, 1, 1);
    chk("R9 overrun on wake", sts_rdata, 4'b1101);
    chk("R5 data kept on wake", rx_data, 8'h81);
    wr_sts(4'b0000);

    // gating R10
    set_ctl(5'b10001);
    send(8'h99, 0, 0, 1);
    chk("R10 plain format accepted", rx_data, 8'h99);
    chk("R10 flag bit kept", sts_rdata, 4'b1001);
    chk("R10 arm stays", ctl_rdata, 5'b10001);
    wr_sts(4'b0000);
    set_ctl(5'b10111);
    send(8'h42, 1, 0, 1);
    chk("R10 clocked mode accepted", rx_data, 8'h42);
    chk("R10 clocked status", sts_rdata, 4'b0001);
    chk("R10 clocked arm stays", ctl_rdata, 5'b10111);

    wait_clk(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule